// File: doc/BRIEF.md
# Interrupt Enable Clear Register Bank

This block keeps one enable bit for each of 64 interrupt lines and lets a processor change those bits through a small memory-mapped register window. Two clear-enable words remove lines from the enabled set. Writing a 1 to a bit disables the matching line, and a 0 in a bit leaves that line as it is. Two set-enable words do the reverse, which lets the enables be built up before they are torn down. All four words read back the live enable state instead of any stored write data.

Only privileged accesses are accepted. An unprivileged access changes nothing, returns zero data and raises a one-cycle bus-error flag. Offsets that map to none of the four words read as zero and ignore writes, and they do not raise an error. The 64-bit enable vector is driven straight from the state flops, so the downstream interrupt logic can gate its request lines with it.

The reset input is asynchronous and active low. Its release is synchronised inside the block, so the bank becomes usable two clock edges after the reset input goes high.

Top module: `irqen_bank`

## Requirements
- R1: While reset is held and after it is released, with no access made, the enable vector, the read data and the error flag are all zero.
- R2: Offset 0x100 is the set word and 0x180 the clear word for lines 0 to 31, where bit n maps to line n. Offset 0x104 is the set word and 0x184 the clear word for lines 32 to 63, where bit n maps to line n+32.
- R3: A privileged write to a clear word clears every enable bit whose data bit is 1, and the change is visible at the enable output right after the clock edge of the write.
- R4: In a privileged write to a clear word, a data bit of 0 leaves the matching enable unchanged, and the enables of the other word stay unchanged.
- R5: A privileged write to a set word sets every enable bit whose data bit is 1 and leaves every other enable unchanged.
- R6: A privileged read of any of the four words returns, in the cycle after the access, the enable state of that word's 32 lines as it stood before the read edge. In any cycle that does not follow a privileged read of a mapped word, the read data is zero.
- R7: An access with the privilege input low leaves the enables unchanged, returns zero read data and asserts the error flag for exactly the following cycle. The error flag is never raised otherwise.
- R8: A privileged access to any other offset, including a misaligned one such as 0x182, reads zero, changes no enable and raises no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| bus_sel_i | input | 1 | Access request in this cycle |
| bus_wr_i | input | 1 | 1 for a write, 0 for a read |
| bus_addr_i | input | 12 | Byte offset of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_priv_i | input | 1 | 1 when the access is privileged |
| bus_rdata_o | output | 32 | Registered read data, valid the cycle after a read |
| bus_err_o | output | 1 | Registered error flag for an unprivileged access |
| irq_en_o | output | 64 | Live per-line enable vector |

## Verification
The assertions check on every cycle the low-word behaviour that follows from one access alone. They cover bits cleared by a 1 and kept by a 0, bits set by a set write, read data equal to the prior enables, denial with a stable state and an error flag, and the quiet cycle after no access. The high word, the boundary lines 32 and 63, unmapped and misaligned offsets, and long random mixes in which the history of earlier accesses decides the expected enables can only be shown by the bench. The bench drives those scenarios and compares them against its own 64-bit model.

// File: rtl/irqen_pkg.sv
package irqen_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned STRIDE = 4;

  typedef enum logic [1:0] {
    ACC_IDLE   = 2'd0,
    ACC_OK     = 2'd1,
    ACC_DENIED = 2'd2
  } acc_e;
endpackage

// File: rtl/irqen_rst_sync.sv
module irqen_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/irqen_decode.sv
module irqen_decode #(
  parameter int unsigned          ADDR_W    = 12,
  parameter int unsigned          NUM_WORDS = 2,
  parameter logic [ADDR_W-1:0]    SET_BASE  = 12'h100,
  parameter logic [ADDR_W-1:0]    CLR_BASE  = 12'h180
) (
  input  logic [ADDR_W-1:0]    addr_i,
  output logic [NUM_WORDS-1:0] set_hit_o,
  output logic [NUM_WORDS-1:0] clr_hit_o
);
  import irqen_pkg::*;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    localparam logic [ADDR_W-1:0] SET_ADDR = SET_BASE + ADDR_W'(STRIDE * w);
    localparam logic [ADDR_W-1:0] CLR_ADDR = CLR_BASE + ADDR_W'(STRIDE * w);
    assign set_hit_o[w] = (addr_i == SET_ADDR);
    assign clr_hit_o[w] = (addr_i == CLR_ADDR);
  end
endmodule

// File: rtl/irqen_state.sv
module irqen_state #(
  parameter int unsigned LINES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] set_mask_i,
  input  logic [LINES-1:0] clr_mask_i,
  output logic [LINES-1:0] en_o
);
  logic [LINES-1:0] en_q;
  logic [LINES-1:0] en_d;
  logic             upd;

  // a clear always overrides a set of the same line
  always_comb begin
    upd  = |(set_mask_i | clr_mask_i);
    en_d = (en_q | set_mask_i) & ~clr_mask_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (upd) begin
      en_q <= en_d;
    end
  end

  assign en_o = en_q;
endmodule

// File: rtl/irqen_readback.sv
module irqen_readback #(
  parameter int unsigned LINES     = 64,
  parameter int unsigned NUM_WORDS = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rd_ok_i,
  input  logic [NUM_WORDS-1:0]         word_hit_i,
  input  logic [LINES-1:0]             en_i,
  input  logic                         deny_i,
  output logic [irqen_pkg::WORD_W-1:0] rdata_o,
  output logic                         err_o
);
  import irqen_pkg::*;

  logic [WORD_W-1:0] word_mux;
  logic [WORD_W-1:0] rdata_d;
  logic [WORD_W-1:0] rdata_q;
  logic              err_q;

  always_comb begin
    word_mux = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (word_hit_i[w]) begin
        word_mux = word_mux | en_i[w*WORD_W +: WORD_W];
      end
    end
    rdata_d = rd_ok_i ? word_mux : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      err_q   <= deny_i;
    end
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;
endmodule

// File: rtl/irqen_bank.sv
module irqen_bank #(
  parameter int unsigned       LINES    = 64,
  parameter int unsigned       ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] SET_BASE = 12'h100,
  parameter logic [ADDR_W-1:0] CLR_BASE = 12'h180
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  input  logic              bus_priv_i,
  output logic [31:0]       bus_rdata_o,
  output logic              bus_err_o,
  output logic [LINES-1:0]  irq_en_o
);
  import irqen_pkg::*;

  localparam int unsigned NUM_WORDS = LINES / WORD_W;

  logic                 rst_n_sync;
  logic [NUM_WORDS-1:0] set_hit;
  logic [NUM_WORDS-1:0] clr_hit;
  logic [NUM_WORDS-1:0] word_hit;
  logic [LINES-1:0]     set_mask;
  logic [LINES-1:0]     clr_mask;
  logic [LINES-1:0]     en;
  acc_e                 acc;
  logic                 wr_ok;
  logic                 rd_ok;

  irqen_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n_sync)
  );

  irqen_decode #(
    .ADDR_W    (ADDR_W),
    .NUM_WORDS (NUM_WORDS),
    .SET_BASE  (SET_BASE),
    .CLR_BASE  (CLR_BASE)
  ) u_dec (
    .addr_i    (bus_addr_i),
    .set_hit_o (set_hit),
    .clr_hit_o (clr_hit)
  );

  always_comb begin
    if (!bus_sel_i)       acc = ACC_IDLE;
    else if (!bus_priv_i) acc = ACC_DENIED;
    else                  acc = ACC_OK;
    word_hit = set_hit | clr_hit;
    wr_ok    = (acc == ACC_OK) && bus_wr_i;
    rd_ok    = (acc == ACC_OK) && !bus_wr_i && (|word_hit);
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_mask
    assign set_mask[w*WORD_W +: WORD_W] = (wr_ok && set_hit[w]) ? bus_wdata_i : '0;
    assign clr_mask[w*WORD_W +: WORD_W] = (wr_ok && clr_hit[w]) ? bus_wdata_i : '0;
  end

  irqen_state #(
    .LINES (LINES)
  ) u_state (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .set_mask_i (set_mask),
    .clr_mask_i (clr_mask),
    .en_o       (en)
  );

  irqen_readback #(
    .LINES     (LINES),
    .NUM_WORDS (NUM_WORDS)
  ) u_rd (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .rd_ok_i    (rd_ok),
    .word_hit_i (word_hit),
    .en_i       (en),
    .deny_i     (acc == ACC_DENIED),
    .rdata_o    (bus_rdata_o),
    .err_o      (bus_err_o)
  );

  assign irq_en_o = en;
endmodule

// File: rtl/irqen_bank_chk.sv
module irqen_bank_chk #(
  parameter int unsigned       LINES    = 64,
  parameter int unsigned       ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] SET_BASE = 12'h100,
  parameter logic [ADDR_W-1:0] CLR_BASE = 12'h180
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel,
  input logic              wr,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic              priv,
  input logic [31:0]       rdata,
  input logic              err,
  input logic [LINES-1:0]  en
);
  logic clr_lo_wr;
  logic set_lo_wr;
  logic lo_rd;

  assign clr_lo_wr = sel && wr && priv && (addr == CLR_BASE);
  assign set_lo_wr = sel && wr && priv && (addr == SET_BASE);
  assign lo_rd     = sel && !wr && priv && ((addr == CLR_BASE) || (addr == SET_BASE));

  p_clear_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_lo_wr |=> ((en[31:0] & $past(wdata)) == 32'h0));

  p_clear_zeros_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_lo_wr |=> (((en[31:0] & ~$past(wdata)) == ($past(en[31:0]) & ~$past(wdata)))
                   && (en[LINES-1:32] == $past(en[LINES-1:32]))));

  p_set_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    set_lo_wr |=> (((en[31:0] & $past(wdata)) == $past(wdata))
                   && ((en[31:0] & ~$past(wdata)) == ($past(en[31:0]) & ~$past(wdata)))));

  p_read_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lo_rd |=> (rdata == $past(en[31:0])));

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> ((rdata == 32'h0) && !err && $stable(en)));

  p_denied_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !priv) |=> (err && (rdata == 32'h0) && $stable(en)));

  p_err_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(sel && !priv));
endmodule

bind irqen_bank irqen_bank_chk #(
  .LINES    (LINES),
  .ADDR_W   (ADDR_W),
  .SET_BASE (SET_BASE),
  .CLR_BASE (CLR_BASE)
) chk_i (
  .clk   (clk),
  .rst_n (rst_n_sync),
  .sel   (bus_sel_i),
  .wr    (bus_wr_i),
  .addr  (bus_addr_i),
  .wdata (bus_wdata_i),
  .priv  (bus_priv_i),
  .rdata (bus_rdata_o),
  .err   (bus_err_o),
  .en    (irq_en_o)
);

// File: tb/irqen_bank_tb_top.sv
`timescale 1ns/1ps
module irqen_bank_tb_top;
  localparam logic [11:0] S0 = 12'h100;
  localparam logic [11:0] S1 = 12'h104;
  localparam logic [11:0] C0 = 12'h180;
  localparam logic [11:0] C1 = 12'h184;

  logic        clk = 1'b0;
  logic        arst_n;
  logic        sel, wr, priv;
  logic [11:0] addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        err;
  logic [63:0] en;

  logic [63:0] model;
  int          total = 0;
  int          bad   = 0;
  bit          done  = 0;

  always #5 clk = ~clk;

  irqen_bank dut_i (
    .clk         (clk),
    .arst_n      (arst_n),
    .bus_sel_i   (sel),
    .bus_wr_i    (wr),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_priv_i  (priv),
    .bus_rdata_o (rdata),
    .bus_err_o   (err),
    .irq_en_o    (en)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit is_mapped(input logic [11:0] a);
    return (a == S0) || (a == S1) || (a == C0) || (a == C1);
  endfunction

  function automatic logic [31:0] word_of(input logic [63:0] m, input logic [11:0] a);
    return a[2] ? m[63:32] : m[31:0];
  endfunction

  function automatic logic [63:0] next_model(input logic [63:0] m, input bit w, input logic [11:0] a,
                                             input logic [31:0] d, input bit p);
    logic [63:0] sh;
    sh = a[2] ? {d, 32'h0} : {32'h0, d};
    if (!(w && p && is_mapped(a))) return m;
    if (a[7]) return m & ~sh;
    return m | sh;
  endfunction

  task automatic acc(input bit w, input logic [11:0] a, input logic [31:0] d, input bit p, input string tag);
    logic [31:0] exp_rd;
    @(negedge clk);
    sel = 1'b1; wr = w; addr = a; wdata = d; priv = p;
    exp_rd = (!w && p && is_mapped(a)) ? word_of(model, a) : 32'h0;
    model  = next_model(model, w, a, d, p);
    @(posedge clk);
    #1;
    chk(tag, "enable", en, model);
    chk(tag, "rdata", {32'h0, rdata}, {32'h0, exp_rd});
    chk(tag, "err", {63'h0, err}, {63'h0, !p});
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    sel = 1'b0; wr = 1'b0; priv = 1'b0; wdata = 32'hFFFF_FFFF; addr = C0;
    @(posedge clk);
    #1;
    chk("R6", "idle rdata", {32'h0, rdata}, 64'h0);
    chk("R7", "idle err", {63'h0, err}, 64'h0);
    chk("R6", "idle enable", en, model);
  endtask

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [11:0] odd_addrs [5];
    void'($urandom(32'd4242));
    odd_addrs[0] = 12'h108; odd_addrs[1] = 12'h182; odd_addrs[2] = 12'h000;
    odd_addrs[3] = 12'h188; odd_addrs[4] = 12'h1FC;
    model = 64'h0;
    sel = 0; wr = 0; priv = 0; addr = '0; wdata = '0;
    arst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "enable in reset", en, 64'h0);
    chk("R1", "rdata in reset", {32'h0, rdata}, 64'h0);
    chk("R1", "err in reset", {63'h0, err}, 64'h0);
    @(negedge clk);
    arst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "enable after reset", en, 64'h0);
    acc(0, C0, 32'h0, 1, "R1");
    acc(0, C1, 32'h0, 1, "R1");

    // mapping of boundary lines
    acc(1, S1, 32'h8000_0001, 1, "R2");
    chk("R2", "line 32 and 63", en, 64'h8000_0001_0000_0000);
    acc(1, S0, 32'h8000_0001, 1, "R2");
    chk("R2", "line 0 and 31", en, 64'h8000_0001_8000_0001);
    acc(1, S0, 32'hFFFF_FFFF, 1, "R5");
    acc(1, S1, 32'hFFFF_FFFF, 1, "R5");
    acc(0, S1, 32'h0, 1, "R6");
    acc(1, C0, 32'h0000_FF00, 1, "R3");
    acc(1, C1, 32'h8000_0000, 1, "R3");
    chk("R3", "line 63 cleared", {63'h0, en[63]}, 64'h0);
    acc(1, C0, 32'h0, 1, "R4");
    acc(1, S0, 32'h0, 1, "R5");
    acc(0, C0, 32'h0, 1, "R6");
    acc(0, S0, 32'h0, 1, "R6");
    idle_cycle();
    acc(1, C0, 32'hFFFF_FFFF, 0, "R7");
    acc(1, S1, 32'hFFFF_FFFF, 0, "R7");
    acc(0, C1, 32'h0, 0, "R7");
    idle_cycle();
    acc(1, 12'h182, 32'hFFFF_FFFF, 1, "R8");
    acc(1, 12'h108, 32'hFFFF_FFFF, 1, "R8");
    acc(0, 12'h000, 32'h0, 1, "R8");
    acc(0, C1, 32'h0, 1, "R6");

    for (int i = 0; i < 400; i++) begin
      int unsigned k;
      logic [11:0] a;
      bit          w, p;
      logic [31:0] d;
      string       tag;
      k = $urandom_range(0, 9);
      case (k)
        0, 1: a = S0;
        2, 3: a = S1;
        4, 5: a = C0;
        6, 7: a = C1;
        default: a = odd_addrs[$urandom_range(0, 4)];
      endcase
      w = $urandom_range(0, 1) == 1;
      p = $urandom_range(0, 9) != 0;
      d = $urandom();
      if (!p)                 tag = "R7";
      else if (!is_mapped(a)) tag = "R8";
      else if (!w)            tag = "R6";
      else if (a[7])          tag = "R3";
      else                    tag = "R5";
      acc(w, a, d, p, tag);
      if ($urandom_range(0, 7) == 0) idle_cycle();
    end

    idle_cycle();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule